// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is the countdown timer that sits beside a processor's local interrupt controller. Software programs a starting count, a clock divider and a control entry holding an interrupt vector, a mask flag and a repeat flag. The count then falls by one on every divided tick. When it reaches zero the block emits a single-cycle request that carries the programmed vector and an edge-trigger flag. The request goes to the logic that records pending vectors.

Two modes exist. In one-shot mode the count stops at zero after one request. In periodic mode the count reloads itself, so requests recur every starting count plus one ticks. A masked entry keeps the counter running but suppresses every request. The divider is derived from the block's own clock. Any write of the starting count or of the divider setting restarts it from zero.

Top module: `local_irq_timer`

## Requirements
- R1: After reset the control entry reads 0x0001_0000 (masked, one-shot, vector 0), and the starting count, current count, divider setting, request strobe and request vector all read zero.
- R2: A divider write keeps only bits 3, 1 and 0 of the written word (mask 0xB). Reads return the kept value and zeros elsewhere.
- R3: The divider code is {bit3, bit1, bit0} of the divider setting. The counter advances once every 2^((code+1) mod 8) clocks, so code 7 divides by 1 and code 0 divides by 2.
- R4: A write of the starting count (address 1) loads that value into the current count at the same clock edge and restarts the divider. The first decrement follows 2^shift clocks later, so a one-shot request appears count × 2^shift clocks after the write edge.
- R5: The current count (address 2) is readable at all times and falls by one per tick. Writes to address 2 have no effect.
- R6: One-shot mode (bit 17 clear): the request fires on the tick that takes the count from 1 to 0. The count then holds at 0 and no further request fires until the starting count is written again.
- R7: Periodic mode (bit 17 set): the tick that follows a zero count reloads the starting count, so requests recur every starting count + 1 ticks. A starting count of 0 never produces a request.
- R8: While the mask bit (bit 16) is set, no request is raised, but the count keeps running.
- R9: A request is a one-cycle strobe. During that strobe the vector output equals bits 7:0 of the control entry as it stood at the expiry tick, and the level-trigger output stays 0 (edge).
- R10: If a starting-count write lands on the same clock edge as an expiry tick, the write wins. No request is raised, and the count restarts from the written value.
- R11: The control entry (address 0) holds only the vector (bits 7:0), the mask (bit 16) and the periodic flag (bit 17). All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; it also feeds the divider |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 control, 1 starting count, 2 current count (ignored), 3 divider |
| wrData | input | 32 | Write data |
| rdAddr | input | 2 | Read address, same map as for writes |
| rdData | output | 32 | Read data for rdAddr, available in the same cycle |
| irqStrobe | output | 1 | One-cycle expiry request |
| irqVector | output | 8 | Vector carried with the request |
| irqLevelTrig | output | 1 | Trigger mode of the request, always 0 (edge) |

## Verification
A starting-count write and an expiry tick can land on the same clock edge. The load path and the expiry path then compete for the count register and for the strobe. The bench forces this collision with a divide-by-one setting: it lets a count of 5 fall to 1, then writes a new count of 9 so that the write arrives on exactly the edge that would have expired. The bench judges the result by three observations: no strobe after that edge, a current count of 9, and a full-length wait of nine ticks before the next request.

// File: rtl/lct_pkg.sv
package lct_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;
  localparam int SHIFT_W = 3;
  localparam int MASK_BIT = 16;
  localparam int PER_BIT = 17;
  localparam logic [3:0] DIV_KEEP = 4'hB;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_INIT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CUR  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_DIV  = 2'd3;

  typedef struct packed {
    logic loadInit;
    logic tick;
    logic periodic;
    logic masked;
  } cntCtl_t;
endpackage

// File: rtl/lct_prescaler.sv
module lct_prescaler #(
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] limit;
  logic             atLimit;

  always_comb begin
    limit   = ~({PRE_W{1'b1}} << shift);
    atLimit = (preCnt == limit);
    tick    = atLimit && !restart;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (restart || atLimit) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end
endmodule

// File: rtl/lct_ctrl.sv
module lct_ctrl
  import lct_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [CNT_W-1:0]  curCount,
  output logic [DATA_W-1:0] rdData,
  output cntCtl_t           ctlBus,
  output logic [CNT_W-1:0]  loadValue,
  output logic [CNT_W-1:0]  initValue,
  output logic [VEC_W-1:0]  vector
);
  logic [VEC_W-1:0]   vecQ;
  logic               maskQ;
  logic               perQ;
  logic [CNT_W-1:0]   initQ;
  logic [3:0]         divQ;
  logic               wrCtrl, wrInit, wrDiv;
  logic [SHIFT_W-1:0] divCode;
  logic [SHIFT_W-1:0] shift;
  logic               preTick;
  logic [DATA_W-1:0]  ctrlWord;

  always_comb begin
    wrCtrl = wrEn && (wrAddr == ADDR_CTRL);
    wrInit = wrEn && (wrAddr == ADDR_INIT);
    wrDiv  = wrEn && (wrAddr == ADDR_DIV);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecQ  <= '0;
      maskQ <= 1'b1;
      perQ  <= 1'b0;
      initQ <= '0;
      divQ  <= '0;
    end else begin
      if (wrCtrl) begin
        vecQ  <= wrData[VEC_W-1:0];
        maskQ <= wrData[MASK_BIT];
        perQ  <= wrData[PER_BIT];
      end
      if (wrInit) begin
        initQ <= wrData[CNT_W-1:0];
      end
      if (wrDiv) begin
        divQ <= wrData[3:0] & DIV_KEEP;
      end
    end
  end

  always_comb begin
    divCode = {divQ[3], divQ[1:0]};
    shift   = divCode + 3'd1;
  end

  lct_prescaler #(.SHIFT_W(SHIFT_W)) prescale (
    .clk    (clk),
    .rstN   (rstN),
    .restart(wrInit || wrDiv),
    .shift  (shift),
    .tick   (preTick)
  );

  always_comb begin
    ctlBus.loadInit = wrInit;
    ctlBus.tick     = preTick;
    ctlBus.periodic = perQ;
    ctlBus.masked   = maskQ;
    loadValue       = wrData[CNT_W-1:0];
    initValue       = initQ;
    vector          = vecQ;
  end

  always_comb begin
    ctrlWord                = '0;
    ctrlWord[VEC_W-1:0]     = vecQ;
    ctrlWord[MASK_BIT]      = maskQ;
    ctrlWord[PER_BIT]       = perQ;
    unique case (rdAddr)
      ADDR_CTRL: rdData = ctrlWord;
      ADDR_INIT: rdData = DATA_W'(initQ);
      ADDR_CUR:  rdData = DATA_W'(curCount);
      default:   rdData = DATA_W'(divQ);
    endcase
  end
endmodule

// File: rtl/lct_datapath.sv
module lct_datapath
  import lct_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCtl_t          ctlBus,
  input  logic [CNT_W-1:0] loadValue,
  input  logic [CNT_W-1:0] initValue,
  input  logic [VEC_W-1:0] vector,
  output logic [CNT_W-1:0] curCount,
  output logic             irqStrobe,
  output logic [VEC_W-1:0] irqVector
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] curQ;
  logic             strobeQ;
  logic [VEC_W-1:0] vecOutQ;
  logic             expiring;

  always_comb begin
    expiring = ctlBus.tick && !ctlBus.loadInit && (curQ == ONE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curQ    <= '0;
      strobeQ <= 1'b0;
      vecOutQ <= '0;
    end else begin
      strobeQ <= expiring && !ctlBus.masked;
      if (expiring && !ctlBus.masked) begin
        vecOutQ <= vector;
      end
      if (ctlBus.loadInit) begin
        curQ <= loadValue;
      end else if (ctlBus.tick) begin
        if (curQ == '0) begin
          if (ctlBus.periodic) begin
            curQ <= initValue;
          end
        end else begin
          curQ <= curQ - ONE;
        end
      end
    end
  end

  always_comb begin
    curCount  = curQ;
    irqStrobe = strobeQ;
    irqVector = vecOutQ;
  end
endmodule

// File: rtl/local_irq_timer.sv
module local_irq_timer
  import lct_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irqStrobe,
  output logic [VEC_W-1:0]  irqVector,
  output logic              irqLevelTrig
);
  cntCtl_t          ctlBus;
  logic [CNT_W-1:0] loadValue;
  logic [CNT_W-1:0] initValue;
  logic [VEC_W-1:0] vector;
  logic [CNT_W-1:0] curCount;

  lct_ctrl #(.CNT_W(CNT_W), .VEC_W(VEC_W)) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .rdAddr   (rdAddr),
    .curCount (curCount),
    .rdData   (rdData),
    .ctlBus   (ctlBus),
    .loadValue(loadValue),
    .initValue(initValue),
    .vector   (vector)
  );

  lct_datapath #(.CNT_W(CNT_W), .VEC_W(VEC_W)) dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctlBus   (ctlBus),
    .loadValue(loadValue),
    .initValue(initValue),
    .vector   (vector),
    .curCount (curCount),
    .irqStrobe(irqStrobe),
    .irqVector(irqVector)
  );

  assign irqLevelTrig = 1'b0;
endmodule

// File: rtl/lct_checker.sv
module lct_checker
  import lct_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              irqStrobe,
  input logic [VEC_W-1:0]  irqVector,
  input logic [CNT_W-1:0]  curCount,
  input logic              masked,
  input logic              periodic,
  input logic [VEC_W-1:0]  vector
);
  logic initWrite;
  assign initWrite = wrEn && (wrAddr == ADDR_INIT);

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqStrobe |=> !irqStrobe);

  // R9
  vector_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqStrobe |-> (irqVector == $past(vector)));

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    masked |=> !irqStrobe);

  // R6
  strobe_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqStrobe |-> (curCount == '0));

  // R4
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    initWrite |=> (curCount == $past(wrData[CNT_W-1:0])));

  // R6
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!periodic && (curCount == '0) && !initWrite) |=> (curCount == '0));

  // R10
  write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    initWrite |=> !irqStrobe);
endmodule

bind local_irq_timer lct_checker #(.CNT_W(CNT_W), .VEC_W(VEC_W)) chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .wrData   (wrData),
  .irqStrobe(irqStrobe),
  .irqVector(irqVector),
  .curCount (curCount),
  .masked   (ctlBus.masked),
  .periodic (ctlBus.periodic),
  .vector   (vector)
);

// File: tb/local_irq_timer_test.sv
module local_irq_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        irqStrobe;
  logic [7:0]  irqVector;
  logic        irqLevelTrig;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  local_irq_timer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irqStrobe(irqStrobe),
    .irqVector(irqVector), .irqLevelTrig(irqLevelTrig)
  );

  typedef struct packed {
    logic [3:0]  div;
    logic [31:0] init;
    logic        per;
    logic [7:0]  vec;
  } row_t;

  localparam row_t TABLE [7] = '{
    '{div: 4'hB, init: 32'd5, per: 1'b0, vec: 8'h31},
    '{div: 4'h0, init: 32'd3, per: 1'b0, vec: 8'h42},
    '{div: 4'h1, init: 32'd4, per: 1'b0, vec: 8'h53},
    '{div: 4'h8, init: 32'd2, per: 1'b0, vec: 8'h64},
    '{div: 4'h3, init: 32'd3, per: 1'b0, vec: 8'h75},
    '{div: 4'hA, init: 32'd1, per: 1'b0, vec: 8'h86},
    '{div: 4'hB, init: 32'd4, per: 1'b1, vec: 8'hF7}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; the write takes effect on the next posedge
  task automatic writeReg(input logic [1:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic waitStrobe(input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (irqStrobe) begin
        n = i;
        return;
      end
    end
  endtask

  task automatic countStrobes(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (irqStrobe) n++;
    end
  endtask

  function automatic int divClocks(input logic [3:0] v);
    logic [2:0] code;
    code = {v[3], v[1:0]};
    return 1 << ((int'(code) + 1) % 8);
  endfunction

  function automatic logic [31:0] ctrlVal(input logic m, input logic p, input logic [7:0] v);
    return {14'd0, p, m, 8'd0, v};
  endfunction

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readReg(2'd0, r); check("R1 ctrl", r, 32'h0001_0000);
    readReg(2'd1, r); check("R1 init", r, 32'd0);
    readReg(2'd2, r); check("R1 cur", r, 32'd0);
    readReg(2'd3, r); check("R1 div", r, 32'd0);
    check("R1 strobe", {31'd0, irqStrobe}, 32'd0);
    check("R1 vector", {24'd0, irqVector}, 32'd0);

    // R11 only vector, mask and periodic bits held
    writeReg(2'd0, 32'hFFFF_FFFF);
    readReg(2'd0, r); check("R11 ctrl fields", r, 32'h0003_00FF);
    // R2 divider keeps bits 3,1,0
    writeReg(2'd3, 32'hFFFF_FFFF);
    readReg(2'd3, r); check("R2 div mask", r, 32'h0000_000B);
    writeReg(2'd3, 32'h0000_0004);
    readReg(2'd3, r); check("R2 div bit2 dropped", r, 32'h0);

    // R3 R4 R9 table of divider, count and mode vectors
    foreach (TABLE[i]) begin
      writeReg(2'd0, ctrlVal(1'b0, TABLE[i].per, TABLE[i].vec));
      writeReg(2'd3, {28'd0, TABLE[i].div});
      writeReg(2'd1, TABLE[i].init);
      waitStrobe(2000, n);
      check("R3 R4 expiry delay", n, TABLE[i].init * divClocks(TABLE[i].div));
      check("R9 vector", {24'd0, irqVector}, {24'd0, TABLE[i].vec});
      check("R9 edge trigger", {31'd0, irqLevelTrig}, 32'd0);
      @(negedge clk);
      check("R9 single cycle", {31'd0, irqStrobe}, 32'd0);
    end

    // R7 periodic period is count + 1
    writeReg(2'd0, ctrlVal(1'b0, 1'b1, 8'h2A));
    writeReg(2'd3, 32'hB);
    writeReg(2'd1, 32'd3);
    waitStrobe(100, n); check("R7 first", n, 32'd3);
    waitStrobe(100, n); check("R7 period", n, 32'd4);
    waitStrobe(100, n); check("R7 period again", n, 32'd4);

    // R7 periodic with count 0 stays silent
    writeReg(2'd1, 32'd0);
    countStrobes(60, n); check("R7 zero count", n, 32'd0);

    // R6 one-shot fires once and holds at zero
    writeReg(2'd0, ctrlVal(1'b0, 1'b0, 8'h11));
    writeReg(2'd1, 32'd2);
    waitStrobe(100, n); check("R6 oneshot delay", n, 32'd2);
    countStrobes(60, n); check("R6 no repeat", n, 32'd0);
    readReg(2'd2, r); check("R6 hold zero", r, 32'd0);

    // R8 masked: counts but no request
    writeReg(2'd0, ctrlVal(1'b1, 1'b0, 8'h22));
    writeReg(2'd1, 32'd3);
    countStrobes(20, n); check("R8 masked silent", n, 32'd0);
    readReg(2'd2, r); check("R8 counted down", r, 32'd0);

    // R5 current count readout and ignored write
    writeReg(2'd0, ctrlVal(1'b0, 1'b0, 8'h33));
    writeReg(2'd1, 32'd100);
    repeat (10) @(negedge clk);
    readReg(2'd2, r); check("R5 readout", r, 32'd90);
    writeReg(2'd2, 32'h1234);
    readReg(2'd2, r); check("R5 write ignored", r, 32'd89);

    // R10 count write on the expiry edge wins
    writeReg(2'd1, 32'd5);
    repeat (4) @(negedge clk);
    readReg(2'd2, r); check("R10 at one", r, 32'd1);
    writeReg(2'd1, 32'd9);
    check("R10 no strobe", {31'd0, irqStrobe}, 32'd0);
    readReg(2'd2, r); check("R10 reloaded", r, 32'd9);
    waitStrobe(100, n); check("R10 full wait", n, 32'd9);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule